// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a logical address, made of a 16-bit segment register value and an effective address, into a 32-bit linear address. A mode input chooses how the segment value is read. When the mode input is low, the segment value is a paragraph number: it is shifted left by four bits and the offset is added to it. When the mode input is high, the segment value is a selector that picks one 8-byte descriptor from the global descriptor table.

In the selector case the block works out where the descriptor sits, using a 48-bit table register. It then makes one 64-bit read over a request/valid memory port. From the returned descriptor it takes the segment base and the limit, scaling the limit when the granularity bit is set. It checks the offset against that limit and returns either the sum of base and offset or a fault. Requests enter over a valid/ready handshake, and `req_ready` falls while a descriptor read is outstanding. Each result appears as a single-cycle `rsp_valid` pulse. The result side has no back-pressure, so the consumer must take the result in the cycle it is presented.

Top module: `segment_translator`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0.
- R2: A request accepted with `prot_en` = 0 responds in the next cycle with `rsp_fault` = 0 and `rsp_lin` = ((`seg_val` << 4) + `eff_addr`) mod 2^32. It issues no memory read.
- R3: A request accepted with `prot_en` = 1 and no table fault raises `mem_rd_req`. The read address is the table base (`gtab_reg[47:16]`) plus eight times the selector index (`seg_val[15:3]`), modulo 2^32. `mem_rd_req` and `mem_rd_addr` stay constant until `mem_rd_valid` is seen.
- R4: In `mem_rd_data`, byte k occupies bits 8k+7:8k. The segment base is bytes 7, 4, 3 and 2, most significant first. The 20-bit limit is byte 6 bits 3:0 above bytes 1 and 0, and the granularity bit is byte 6 bit 7. The response follows in the cycle after `mem_rd_valid`, with `rsp_lin` = (base + `eff_addr`) mod 2^32.
- R5: When granularity is 0, an offset greater than the 20-bit limit gives `rsp_fault` = 1. An offset equal to the limit does not fault. Any faulting response carries `rsp_lin` = 0.
- R6: When granularity is 1, the effective limit is (limit << 12) | 0xFFF, and offsets are checked against this value.
- R7: When index·8 + 7 is greater than the table limit (`gtab_reg[15:0]`), the request faults in the next cycle without a memory read. When it is equal to the table limit, the descriptor is fetched.
- R8: A selector with the table bit (`seg_val[2]`) set to 1 faults in the next cycle without a memory read.
- R9: The requested privilege bits (`seg_val[1:0]`) have no effect on the read address or on the result.
- R10: `req_ready` is 0 while a descriptor read is outstanding. Changes on `seg_val`, `eff_addr`, `gtab_reg` and `prot_en` after acceptance do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle, so a request is accepted |
| prot_en | input | 1 | 1 selects selector translation, 0 selects shift-and-add |
| seg_val | input | 16 | Segment register value or selector |
| eff_addr | input | EA_W | Effective address (offset) |
| gtab_reg | input | TLIM_W+32 | Table register: base in the upper 32 bits, limit in the lower TLIM_W bits |
| mem_rd_req | output | 1 | Descriptor read request, held until data returns |
| mem_rd_addr | output | 32 | Byte address of the descriptor |
| mem_rd_valid | input | 1 | Descriptor data valid |
| mem_rd_data | input | 64 | Descriptor contents |
| rsp_valid | output | 1 | Single-cycle result pulse |
| rsp_fault | output | 1 | Translation faulted |
| rsp_lin | output | 32 | Linear address, 0 on fault |

## Verification
The bench builds the block with its default parameters: a 32-bit effective address and a 16-bit table limit. With these values a full 32-bit offset can be tested against a granular 4 GB limit. They also allow the largest index, 8191, to sit exactly at the end of a 64 KB table. The bench memory model returns data after 0, 1, 3 or 7 idle cycles, which exercises the hold rule of the read port and the freeze of request inputs at several wait lengths.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int LIN_W  = 32;
  localparam int SEG_W  = 16;
  localparam int DLIM_W = 20;
  localparam int DESC_W = 64;

  typedef enum logic {ST_IDLE, ST_FETCH} segx_state_e;

  typedef struct packed {
    logic [LIN_W-1:0]  base;
    logic [DLIM_W-1:0] limit;
    logic              gran;
  } seg_desc_t;

  function automatic seg_desc_t unpack_desc(input logic [DESC_W-1:0] raw);
    seg_desc_t d;
    d.base  = {raw[63:56], raw[39:16]};
    d.limit = {raw[51:48], raw[15:0]};
    d.gran  = raw[55];
    return d;
  endfunction
endpackage

// File: rtl/segx_sel_decode.sv
module segx_sel_decode
  import segx_pkg::*;
#(
  parameter int TLIM_W = 16
) (
  input  logic [SEG_W-1:0]  sel,
  input  logic [LIN_W-1:0]  tab_base,
  input  logic [TLIM_W-1:0] tab_lim,
  output logic [LIN_W-1:0]  desc_addr,
  output logic              local_sel,
  output logic              over_tab
);
  localparam int IDX_W = SEG_W - 3;

  logic [IDX_W-1:0] idx;
  logic [LIN_W-1:0] last_byte;

  assign idx       = sel[SEG_W-1:3];
  assign local_sel = sel[2];
  assign desc_addr = tab_base + LIN_W'({idx, 3'b000});
  assign last_byte = LIN_W'({idx, 3'b111});
  assign over_tab  = last_byte > LIN_W'(tab_lim);
endmodule

// File: rtl/segx_lim_check.sv
module segx_lim_check
  import segx_pkg::*;
#(
  parameter int EA_W = 32
) (
  input  logic [DESC_W-1:0] raw_desc,
  input  logic [EA_W-1:0]   ofs,
  output logic [LIN_W-1:0]  lin,
  output logic              fault
);
  seg_desc_t        d;
  logic [LIN_W-1:0] eff_lim;

  assign d = unpack_desc(raw_desc);

  generate
    if (LIN_W > DLIM_W + 12) begin : g_pad
      assign eff_lim = d.gran ? LIN_W'({d.limit, 12'hFFF}) : LIN_W'(d.limit);
    end else begin : g_full
      assign eff_lim = d.gran ? {d.limit, 12'hFFF} : LIN_W'(d.limit);
    end
  endgenerate

  assign fault = LIN_W'(ofs) > eff_lim;
  assign lin   = fault ? '0 : d.base + LIN_W'(ofs);
endmodule

// File: rtl/segment_translator.sv
module segment_translator
  import segx_pkg::*;
#(
  parameter int EA_W   = 32,
  parameter int TLIM_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    prot_en,
  input  logic [SEG_W-1:0]        seg_val,
  input  logic [EA_W-1:0]         eff_addr,
  input  logic [TLIM_W+LIN_W-1:0] gtab_reg,
  output logic                    mem_rd_req,
  output logic [LIN_W-1:0]        mem_rd_addr,
  input  logic                    mem_rd_valid,
  input  logic [DESC_W-1:0]       mem_rd_data,
  output logic                    rsp_valid,
  output logic                    rsp_fault,
  output logic [LIN_W-1:0]        rsp_lin
);
  localparam int SHIFT = 4;

  segx_state_e      st;
  logic [LIN_W-1:0] addr_q;
  logic [EA_W-1:0]  ea_q;
  logic             accept;
  logic [LIN_W-1:0] dec_addr;
  logic             dec_local;
  logic             dec_over;
  logic [LIN_W-1:0] real_lin;
  logic [LIN_W-1:0] chk_lin;
  logic             chk_fault;

  segx_sel_decode #(.TLIM_W(TLIM_W)) u_dec (
    .sel      (seg_val),
    .tab_base (gtab_reg[TLIM_W+LIN_W-1:TLIM_W]),
    .tab_lim  (gtab_reg[TLIM_W-1:0]),
    .desc_addr(dec_addr),
    .local_sel(dec_local),
    .over_tab (dec_over)
  );

  segx_lim_check #(.EA_W(EA_W)) u_chk (
    .raw_desc(mem_rd_data),
    .ofs     (ea_q),
    .lin     (chk_lin),
    .fault   (chk_fault)
  );

  assign req_ready   = (st == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign real_lin    = (LIN_W'(seg_val) << SHIFT) + LIN_W'(eff_addr);
  assign mem_rd_req  = (st == ST_FETCH);
  assign mem_rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      ea_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_lin   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!prot_en) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_lin   <= real_lin;
            end else if (dec_local || dec_over) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_lin   <= '0;
            end else begin
              st     <= ST_FETCH;
              addr_q <= dec_addr;
              ea_q   <= eff_addr;
            end
          end
        end
        ST_FETCH: begin
          if (mem_rd_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= chk_fault;
            rsp_lin   <= chk_lin;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module segx_checker #(
  parameter int EA_W   = 32,
  parameter int TLIM_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        prot_en,
  input logic [15:0] seg_val,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_lin
);
  assert_real_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !prot_en |=> rsp_valid && !rsp_fault && !mem_rd_req);

  assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  assert_rsp_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_valid |=> rsp_valid && !mem_rd_req);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_lin == 32'h0);

  assert_local_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && prot_en && seg_val[2] |=> rsp_valid && rsp_fault && !mem_rd_req);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);
endmodule

bind segment_translator segx_checker #(.EA_W(EA_W), .TLIM_W(TLIM_W)) i_segx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .prot_en     (prot_en),
  .seg_val     (seg_val),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .rsp_valid   (rsp_valid),
  .rsp_fault   (rsp_fault),
  .rsp_lin     (rsp_lin)
);

// File: tb/test_segment_translator.sv
module test_segment_translator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        prot_en = 1'b0;
  logic [15:0] seg_val = '0;
  logic [31:0] eff_addr = '0;
  logic [47:0] gtab_reg = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_lin;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mem_desc = '0;
  int          mem_lat = 0;
  int          wait_cnt = 0;
  logic        pending = 1'b0;
  logic [31:0] seen_addr = '0;
  int          reads = 0;

  always #2 clk = ~clk;

  segment_translator i_segment_translator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .prot_en(prot_en), .seg_val(seg_val), .eff_addr(eff_addr), .gtab_reg(gtab_reg),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_lin(rsp_lin)
  );

  // Memory model: reacts away from the active edge.
  always @(negedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pending) begin
      if (wait_cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_desc;
        pending      <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end else if (mem_rd_req && !mem_rd_valid) begin
      pending   <= 1'b1;
      wait_cnt  <= mem_lat;
      seen_addr <= mem_rd_addr;
      reads     <= reads + 1;
    end
  end

  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                          input logic g);
    logic [63:0] r;
    r = '0;
    r[15:0]  = lim[15:0];
    r[39:16] = base[23:0];
    r[47:40] = 8'h92;
    r[51:48] = lim[19:16];
    r[55]    = g;
    r[54]    = 1'b1;
    r[63:56] = base[31:24];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic        o_fault;
  logic [31:0] o_lin;
  int          o_waits;
  int          o_reads;
  logic        o_busy_ok;

  task automatic xlate(input logic pe, input logic [15:0] sel, input logic [31:0] ea,
                       input logic [47:0] gt, input int lat);
    int r0;
    r0 = reads;
    mem_lat = lat;
    o_busy_ok = 1'b1;
    @(negedge clk);
    prot_en = pe; seg_val = sel; eff_addr = ea; gtab_reg = gt; req_valid = 1'b1;
    @(posedge clk);
    o_waits = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      prot_en = ~pe; seg_val = ~sel; eff_addr = ~ea; gtab_reg = ~gt;
      if (rsp_valid) break;
      if (req_ready) o_busy_ok = 1'b0;
      o_waits++;
      if (o_waits > 60) break;
    end
    o_fault = rsp_fault;
    o_lin   = rsp_lin;
    o_reads = reads - r0;
  endtask

  task automatic t_reset;
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_rd_req", mem_rd_req, 0);
  endtask

  task automatic t_real;
    xlate(1'b0, 16'h1234, 32'h0005, 48'h0, 0);
    check("R2 lin", o_lin, 32'h12345);
    check("R2 fault", o_fault, 0);
    check("R2 latency", o_waits, 0);
    check("R2 no read", o_reads, 0);
    xlate(1'b0, 16'hFFFF, 32'hFFFF_FFF0, 48'h0, 0);
    check("R2 wrap", o_lin, 32'h000F_FFE0);
  endtask

  task automatic t_prot_basic;
    mem_desc = mk_desc(32'h100, 20'hFFF, 1'b0);
    xlate(1'b1, 16'h0013, 32'h10, {32'h0000_2000, 16'h0FFF}, 1);
    check("R3 addr", seen_addr, 32'h2010);
    check("R3 one read", o_reads, 1);
    check("R4 lin", o_lin, 32'h110);
    check("R4 fault", o_fault, 0);
    check("R4 latency", o_waits, 3);
    check("R10 busy", o_busy_ok, 1);
  endtask

  task automatic t_layout;
    mem_desc = mk_desc(32'hA1B2_C3D4, 20'hFFFFF, 1'b0);
    xlate(1'b1, 16'h0008, 32'h0000_1000, {32'h0010_0000, 16'hFFFF}, 7);
    check("R3 addr lat7", seen_addr, 32'h0010_0008);
    check("R4 base bytes", o_lin, 32'hA1B2_D3D4);
    check("R4 latency lat7", o_waits, 9);
    check("R10 inputs frozen", o_fault, 0);
    mem_desc = mk_desc(32'hFFFF_FF00, 20'hFFFFF, 1'b1);
    xlate(1'b1, 16'h0008, 32'h0000_0200, {32'h0010_0000, 16'hFFFF}, 0);
    check("R4 base wrap", o_lin, 32'h0000_0100);
  endtask

  task automatic t_limit;
    mem_desc = mk_desc(32'h4000, 20'h0_0FFF, 1'b0);
    xlate(1'b1, 16'h0010, 32'hFFF, {32'h0, 16'hFFFF}, 3);
    check("R5 at limit fault", o_fault, 0);
    check("R5 at limit lin", o_lin, 32'h4FFF);
    xlate(1'b1, 16'h0010, 32'h1000, {32'h0, 16'hFFFF}, 3);
    check("R5 over fault", o_fault, 1);
    check("R5 over lin", o_lin, 0);
    mem_desc = mk_desc(32'h4000, 20'h1_2345, 1'b0);
    xlate(1'b1, 16'h0010, 32'h1_2346, {32'h0, 16'hFFFF}, 0);
    check("R5 high limit bits", o_fault, 1);
  endtask

  task automatic t_gran;
    mem_desc = mk_desc(32'h0, 20'h00001, 1'b1);
    xlate(1'b1, 16'h0018, 32'h1FFF, {32'h0, 16'hFFFF}, 1);
    check("R6 at limit", o_fault, 0);
    check("R6 at limit lin", o_lin, 32'h1FFF);
    xlate(1'b1, 16'h0018, 32'h2000, {32'h0, 16'hFFFF}, 1);
    check("R6 over", o_fault, 1);
    mem_desc = mk_desc(32'h0, 20'hFFFFF, 1'b1);
    xlate(1'b1, 16'h0018, 32'hFFFF_FFFF, {32'h0, 16'hFFFF}, 1);
    check("R6 full 4GB", o_fault, 0);
  endtask

  task automatic t_table;
    mem_desc = mk_desc(32'h500, 20'hFFFFF, 1'b0);
    xlate(1'b1, 16'h0010, 32'h1, {32'h0000_3000, 16'h0017}, 0);
    check("R7 last fits fault", o_fault, 0);
    check("R7 last fits addr", seen_addr, 32'h3010);
    xlate(1'b1, 16'h0018, 32'h1, {32'h0000_3000, 16'h0017}, 0);
    check("R7 beyond fault", o_fault, 1);
    check("R7 beyond no read", o_reads, 0);
    check("R7 beyond latency", o_waits, 0);
    xlate(1'b1, 16'hFFF8, 32'h1, {32'h0000_3000, 16'hFFFF}, 0);
    check("R7 max index addr", seen_addr, 32'h0001_2FF8);
    check("R7 max index fault", o_fault, 0);
  endtask

  task automatic t_local;
    xlate(1'b1, 16'h0014, 32'h1, {32'h0, 16'hFFFF}, 0);
    check("R8 fault", o_fault, 1);
    check("R8 no read", o_reads, 0);
    check("R8 lin", o_lin, 0);
  endtask

  task automatic t_rpl;
    logic [31:0] l0;
    mem_desc = mk_desc(32'h7700, 20'hFFFFF, 1'b0);
    xlate(1'b1, 16'h0020, 32'h44, {32'h0000_8000, 16'hFFFF}, 1);
    l0 = o_lin;
    xlate(1'b1, 16'h0023, 32'h44, {32'h0000_8000, 16'hFFFF}, 1);
    check("R9 addr", seen_addr, 32'h8020);
    check("R9 lin", o_lin, l0);
    check("R9 lin value", o_lin, 32'h7744);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_prot_basic();
    t_layout();
    t_limit();
    t_gran();
    t_table();
    t_local();
    t_rpl();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule